// File: doc/BRIEF.md
# Watchdog Counter with Reset Control

The block is an 8-bit up-counter that advances on a prescaled tick whenever the timer is enabled. It has two modes, chosen by a port. In watchdog mode, the wrap from 0xFF to 0x00 sets a sticky overflow flag. If reset generation is enabled, the wrap also drives a chip-wide reset output high for a fixed number of cycles. In interval mode, the wrap raises a one-cycle event and the counter keeps counting.

Software reaches the block over a small register bus with one address bit:

- Address 0 is the counter.
- Address 1 is the status/control byte. Its bit 7 is the overflow flag, bit 6 is the reset enable, bit 5 reads 0, and bits 4..0 read 1.

Every write carries a 16-bit word whose upper byte must hold a key, otherwise the write is dropped. Clearing the flag takes two steps: first a status read that sees the flag set, then a flag-keyed write of 0 to bit 7. The status byte returns to 0x1F only on the external reset pin. The watchdog's own reset pulse leaves the status byte as it was.

Top module: `wdog_rstctl`

## Requirements
- R1: In the cycle after the external reset pin (`rst_ext`), the status byte reads 0x1F, the counter reads 0x00, and `rst_o` and `irq_o` are low.
- R2: While `run` is 1, the counter adds one on each cycle with `tick` high. While `run` is 0, the counter is held at 0x00 and ticks are ignored.
- R3: A write to address 0 whose upper byte is 0x5A loads the lower byte into the counter. Any other upper byte leaves the counter unchanged.
- R4: In watchdog mode (`wd_mode`=1), a tick at count 0xFF wraps the counter to 0x00 and sets status bit 7.
- R5: In interval mode (`wd_mode`=0), the wrap leaves bit 7 at 0, raises `irq_o` for exactly one cycle, and the counter continues from 0x00.
- R6: Bit 7 is cleared only by a write to address 1 with upper byte 0xA5 and lower bit 7 = 0, issued after a read of address 1 that returned bit 7 = 1. Without such a read, or with bit 7 written as 1, the flag stays set.
- R7: With bit 6 = 1, a watchdog-mode wrap drives `rst_o` high for exactly RST_CYCLES (default 16) cycles. During that time the counter stays at 0x00 despite ticks.
- R8: The watchdog's own reset pulse leaves bits 7 and 6 of the status byte unchanged.
- R9: A write to address 1 with upper byte 0x5A copies lower bit 6 into bit 6. Other keys leave bit 6 unchanged, and bits 5..0 ignore all writes.
- R10: `rd_data` takes the addressed byte at the clock edge where `rd_en` is sampled high, and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ext | input | 1 | External reset pin, synchronous, active high |
| tick | input | 1 | Prescaled count enable |
| run | input | 1 | Timer enable; when low, the counter is held at zero |
| wd_mode | input | 1 | 1 selects watchdog mode, 0 selects interval mode |
| addr | input | 1 | Register select: 0 = counter, 1 = status/control |
| wdata | input | 16 | Write word: key in [15:8], data in [7:0] |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| rst_o | output | 1 | Internal chip reset pulse |
| irq_o | output | 1 | One-cycle interval event |

## Verification
Each result has its own latency:

- Read data, the counter, the flag, `irq_o` and `rst_o` all update at the same edge that samples the causing strobe or tick. The bench drives on falling edges and samples at the following falling edge, which is one rising edge later.
- `rst_o` is measured by counting falling edges while it stays high. The count is compared with RST_CYCLES.
- `irq_o` is sampled at the first falling edge after the wrapping tick and again one cycle later, to prove it lasts one cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 2 * BYTE_W;

  localparam logic [BYTE_W-1:0] KEY_COUNT = 8'h5A;
  localparam logic [BYTE_W-1:0] KEY_CTRL  = 8'h5A;
  localparam logic [BYTE_W-1:0] KEY_FLAG  = 8'hA5;

  localparam int unsigned FLAG_BIT = 7;
  localparam int unsigned RSTE_BIT = 6;

  typedef enum logic {
    SEL_COUNT  = 1'b0,
    SEL_STATUS = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         hold,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  // the wrap is seen only when the counter really steps from the top value
  assign ovf = run && !hold && !load && tick && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst || hold || !run) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_status.sv
module wdog_status
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ext,
  input  logic              wd_mode,
  input  logic              ovf,
  input  logic              rd_stat,
  input  logic              wr_stat,
  input  logic [WORD_W-1:0] wdata,
  output logic              flag,
  output logic              rste
);
  logic              armed;
  logic [BYTE_W-1:0] key;
  logic [BYTE_W-1:0] val;
  logic              set_flag;
  logic              clr_flag;

  assign key      = wdata[WORD_W-1:BYTE_W];
  assign val      = wdata[BYTE_W-1:0];
  assign set_flag = ovf && wd_mode;
  assign clr_flag = wr_stat && (key == KEY_FLAG) && !val[FLAG_BIT] && armed;

  // only the pin reset touches this state; the watchdog pulse does not
  always_ff @(posedge clk) begin
    if (rst_ext) begin
      flag  <= 1'b0;
      armed <= 1'b0;
      rste  <= 1'b0;
    end else begin
      if (set_flag) begin
        flag <= 1'b1;
      end else if (clr_flag) begin
        flag <= 1'b0;
      end

      if (clr_flag) begin
        armed <= 1'b0;
      end else if (rd_stat && flag) begin
        armed <= 1'b1;
      end

      if (wr_stat && (key == KEY_CTRL)) begin
        rste <= val[RSTE_BIT];
      end
    end
  end
endmodule

// File: rtl/wdog_rst_stretch.sv
module wdog_rst_stretch #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic busy
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (trig && !busy) begin
      busy   <= 1'b1;
      remain <= LAST;
    end else if (busy) begin
      if (remain == '0) begin
        busy <= 1'b0;
      end else begin
        remain <= remain - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdog_rstctl.sv
module wdog_rstctl
  import wdog_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_ext,
  input  logic              tick,
  input  logic              run,
  input  logic              wd_mode,
  input  logic              addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rst_o,
  output logic              irq_o
);
  logic [CNT_W-1:0]  cnt;
  logic              ovf;
  logic              flag;
  logic              rste;
  logic              cnt_load;
  logic              rd_stat;
  logic              wr_stat;
  logic [BYTE_W-1:0] stat_byte;

  assign cnt_load  = wr_en && (reg_sel_e'(addr) == SEL_COUNT) &&
                     (wdata[WORD_W-1:BYTE_W] == KEY_COUNT);
  assign rd_stat   = rd_en && (reg_sel_e'(addr) == SEL_STATUS);
  assign wr_stat   = wr_en && (reg_sel_e'(addr) == SEL_STATUS);
  assign stat_byte = {flag, rste, 1'b0, 5'b11111};

  wdog_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst_ext),
    .run      (run),
    .hold     (rst_o),
    .tick     (tick),
    .load     (cnt_load),
    .load_val (wdata[CNT_W-1:0]),
    .cnt      (cnt),
    .ovf      (ovf)
  );

  wdog_status u_stat (
    .clk     (clk),
    .rst_ext (rst_ext),
    .wd_mode (wd_mode),
    .ovf     (ovf),
    .rd_stat (rd_stat),
    .wr_stat (wr_stat),
    .wdata   (wdata),
    .flag    (flag),
    .rste    (rste)
  );

  wdog_rst_stretch #(.CYCLES(RST_CYCLES)) u_pulse (
    .clk  (clk),
    .rst  (rst_ext),
    .trig (ovf && wd_mode && rste),
    .busy (rst_o)
  );

  always_ff @(posedge clk) begin
    if (rst_ext) begin
      rd_data <= '0;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= ovf && !wd_mode;
      if (rd_en) begin
        rd_data <= (reg_sel_e'(addr) == SEL_STATUS) ? stat_byte : BYTE_W'(cnt);
      end
    end
  end
endmodule

// File: rtl/wdog_rstctl_chk.sv
module wdog_rstctl_chk #(
  parameter int unsigned RST_CYCLES = 16
) (
  input logic clk,
  input logic rst_ext,
  input logic wd_mode,
  input logic ovf,
  input logic flag,
  input logic wr_stat,
  input logic rst_o,
  input logic irq_o
);
  localparam int unsigned HW = $clog2(RST_CYCLES + 1) + 1;
  logic [HW-1:0] high_len;

  always_ff @(posedge clk) begin
    if (rst_ext)    high_len <= '0;
    else if (rst_o) high_len <= high_len + 1'b1;
    else            high_len <= '0;
  end

  p_wrap_sets_flag_r4: assert property (@(posedge clk) disable iff (rst_ext)
    (ovf && wd_mode) |=> flag);

  p_no_flag_interval_r5: assert property (@(posedge clk) disable iff (rst_ext)
    (!flag && !wd_mode) |=> !flag);

  p_event_one_cycle_r5: assert property (@(posedge clk) disable iff (rst_ext)
    irq_o |=> !irq_o);

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst_ext)
    (flag && !wr_stat) |=> flag);

  p_pulse_bounded_r7: assert property (@(posedge clk) disable iff (rst_ext)
    rst_o |-> (high_len < HW'(RST_CYCLES)));

  p_pulse_length_r7: assert property (@(posedge clk) disable iff (rst_ext)
    $fell(rst_o) |-> (high_len == HW'(RST_CYCLES)));
endmodule

bind wdog_rstctl wdog_rstctl_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk     (clk),
  .rst_ext (rst_ext),
  .wd_mode (wd_mode),
  .ovf     (ovf),
  .flag    (flag),
  .wr_stat (wr_stat),
  .rst_o   (rst_o),
  .irq_o   (irq_o)
);

// File: tb/wdog_rstctl_bench.sv
module wdog_rstctl_bench;
  localparam int unsigned RST_CYCLES = 16;
  localparam logic [1:0] OP_WR = 2'd0;
  localparam logic [1:0] OP_RD = 2'd1;
  localparam logic [1:0] OP_TK = 2'd2;
  localparam int NV = 23;

  // {op, addr, data, expected, requirement}
  localparam logic [30:0] VEC [NV] = '{
    {OP_RD, 1'b1, 16'h0000, 8'h1F, 4'd1},  // R1
    {OP_RD, 1'b0, 16'h0000, 8'h00, 4'd1},  // R1
    {OP_WR, 1'b0, 16'h1205, 8'h00, 4'd3},  // R3 wrong key
    {OP_RD, 1'b0, 16'h0000, 8'h00, 4'd3},
    {OP_WR, 1'b0, 16'h5A05, 8'h00, 4'd3},
    {OP_RD, 1'b0, 16'h0000, 8'h05, 4'd3},
    {OP_TK, 1'b0, 16'h0003, 8'h00, 4'd2},  // R2
    {OP_RD, 1'b0, 16'h0000, 8'h08, 4'd2},
    {OP_WR, 1'b1, 16'h3340, 8'h00, 4'd9},  // R9 wrong key
    {OP_RD, 1'b1, 16'h0000, 8'h1F, 4'd9},
    {OP_WR, 1'b1, 16'h5A40, 8'h00, 4'd9},
    {OP_RD, 1'b1, 16'h0000, 8'h5F, 4'd9},
    {OP_WR, 1'b1, 16'h5A00, 8'h00, 4'd9},
    {OP_RD, 1'b1, 16'h0000, 8'h1F, 4'd9},
    {OP_WR, 1'b0, 16'h5AFE, 8'h00, 4'd4},  // R4
    {OP_TK, 1'b0, 16'h0002, 8'h00, 4'd4},
    {OP_WR, 1'b1, 16'hA500, 8'h00, 4'd6},  // R6 not armed
    {OP_RD, 1'b1, 16'h0000, 8'h9F, 4'd4},
    {OP_WR, 1'b1, 16'hA580, 8'h00, 4'd6},  // R6 writing 1
    {OP_RD, 1'b1, 16'h0000, 8'h9F, 4'd6},
    {OP_WR, 1'b1, 16'hA500, 8'h00, 4'd6},
    {OP_RD, 1'b1, 16'h0000, 8'h1F, 4'd6},
    {OP_RD, 1'b0, 16'h0000, 8'h00, 4'd4}
  };

  logic        clk = 1'b0;
  logic        rst_ext = 1'b1;
  logic        tick = 1'b0;
  logic        run = 1'b0;
  logic        wd_mode = 1'b1;
  logic        addr = 1'b0;
  logic [15:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic        rst_o;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  wdog_rstctl #(.RST_CYCLES(RST_CYCLES)) u_wdog_rstctl (
    .clk(clk), .rst_ext(rst_ext), .tick(tick), .run(run), .wd_mode(wd_mode),
    .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
    .rd_data(rd_data), .rst_o(rst_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R10: data is due at the first falling edge after the sampling edge
  task automatic rd(input logic a, output logic [7:0] v);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_ext = 1'b0;
    run = 1'b1;
    check("R1 rst_o", int'(rst_o), 0);
    check("R1 irq_o", int'(irq_o), 0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [7:0] ex;
      op = VEC[i][30:29];
      ex = VEC[i][11:4];
      if (op == OP_WR) wr(VEC[i][28], VEC[i][27:12]);
      else if (op == OP_TK) ticks(int'(VEC[i][27:12]));
      else begin
        rd(VEC[i][28], v);
        check($sformatf("R%0d vector %0d", VEC[i][3:0], i), int'(v), int'(ex));
      end
    end

    // R7 / R8: reset pulse length, counter held, status kept
    wr(1'b1, 16'h5A40);
    wr(1'b0, 16'h5AFE);
    ticks(2);
    check("R7 pulse started", int'(rst_o), 1);
    tick = 1'b1;
    n = 0;
    while (rst_o && n < 100) begin
      n++;
      @(negedge clk);
    end
    tick = 1'b0;
    check("R7 pulse length", n, RST_CYCLES);
    rd(1'b0, v);
    check("R7 counter held", int'(v), 0);
    rd(1'b1, v);
    check("R8 status kept", int'(v), 8'hDF);
    // R10: no read strobe, rd_data holds while status changes
    wr(1'b1, 16'h5A00);
    @(negedge clk);
    check("R10 hold", int'(rd_data), 8'hDF);

    // R1: pin reset restores the status byte
    rst_ext = 1'b1;
    @(negedge clk);
    rst_ext = 1'b0;
    rd(1'b1, v);
    check("R1 status after pin", int'(v), 8'h1F);

    // R5: interval mode
    wd_mode = 1'b0;
    wr(1'b0, 16'h5AFF);
    ticks(1);
    check("R5 event high", int'(irq_o), 1);
    @(negedge clk);
    check("R5 event one cycle", int'(irq_o), 0);
    check("R5 no reset", int'(rst_o), 0);
    rd(1'b1, v);
    check("R5 no flag", int'(v), 8'h1F);
    ticks(3);
    rd(1'b0, v);
    check("R5 keeps counting", int'(v), 3);

    // R2: run low clears and freezes
    run = 1'b0;
    @(negedge clk);
    rd(1'b0, v);
    check("R2 run low clears", int'(v), 0);
    ticks(2);
    rd(1'b0, v);
    check("R2 run low ignores tick", int'(v), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule